// File: doc/BRIEF.md
# Repeat-Prefix String Sequencer

This block is the loop controller behind a repeated string instruction. It is given a repeat kind, an address width, a wide-operand flag, the element kind and size, a direction, and starting values for the count and for the source and destination pointers. It then asks an external element unit to perform one string element at a time. Each request is a request/acknowledge handshake, and each acknowledge brings back a zero flag and a fault indication.

The sequencer works on a copy of the count. It decrements the count after every successful element and moves both pointers by the element size. Two things end the loop: the count reaching zero, and, for the conditional kinds, the returned zero flag reaching the value that stops the loop. A pending interrupt is checked before each element. When one is pending, the loop stops before that element and leaves the registers so that the instruction can be issued again and carry on where it stopped. A fault leaves the registers as they were before the faulting element and restores the zero flag held before the instruction.

Completion is a one-cycle `done` pulse with a two-bit cause. The final count, pointers and zero flag are held on the outputs until the next start.

Top module: `rep_seq`

## Requirements
- R1: The active count width is 16 bits when `addr_w`=0, 64 bits when `addr_w`=2 and `wide`=1, and 32 bits otherwise. Only those bits are tested and decremented. The bits above them in `cnt_out` keep their `cnt_in` values.
- R2: When the active count is zero at start, no element is requested, and `done` arrives with cause 0 (count exhausted).
- R3: Before each element, a high `irq_pending` stops the loop with cause 2 and without requesting that element. `el_req` never rises in the cycle after `irq_pending` was sampled high.
- R4: Each successful element lowers the active count by exactly one. When the count reaches zero, the loop ends with cause 0 whatever the repeat kind.
- R5: With `rep_kind`=0 (plain repeat), the returned zero flag never ends the loop.
- R6: After a successful element that left the count nonzero, `rep_kind`=1 ends the loop with cause 1 when `el_zf`=0, and `rep_kind`=2 ends it with cause 1 when `el_zf`=1.
- R7: On an interrupt stop, the count and pointers equal their values after the last successful element, so the pointers address the next unprocessed element. `restart` is high with `done` for causes 2 and 3 and low otherwise.
- R8: An acknowledge with `el_fault`=1 ends the loop with cause 3 and leaves the count and pointers unchanged. For compare elements (`cmp_op`=1), `zf_out` returns to `flag_zf_in`.
- R9: After each successful element, both pointers move by the element size in bytes: up when `dir_down`=0, down when it is 1.
- R10: `size_code` 0, 1 and 2 give 1, 2 and 4 bytes. Code 2 becomes 8 bytes when `wide`=1 and `port_op`=0. Port elements stay at 4 bytes.
- R11: For compare elements, `zf_out` follows the `el_zf` of the last successful element and needs no setup. For other elements, it keeps `flag_zf_in`.
- R12: `el_req` stays high until `el_ack`, and every acknowledged request counts as exactly one element attempt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a repeated operation (taken when idle) |
| rep_kind | input | 2 | 0 plain, 1 repeat while equal, 2 repeat while not equal |
| addr_w | input | 2 | 0 16-bit, 1 32-bit, 2 64-bit addressing |
| wide | input | 1 | Wide-operand flag |
| port_op | input | 1 | Element is a port input/output |
| cmp_op | input | 1 | Element is a compare/scan that produces the zero flag |
| size_code | input | 2 | Base element size code |
| dir_down | input | 1 | Pointers decrement when 1 |
| cnt_in | input | REG_W | Starting count register |
| src_in | input | REG_W | Starting source pointer |
| dst_in | input | REG_W | Starting destination pointer |
| flag_zf_in | input | 1 | Zero flag before the instruction |
| irq_pending | input | 1 | Interrupt pending |
| el_req | output | 1 | Element request |
| el_ack | input | 1 | Element acknowledge |
| el_zf | input | 1 | Zero flag returned with acknowledge |
| el_fault | input | 1 | Element faulted |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| cause | output | 2 | 0 count, 1 flag condition, 2 interrupt, 3 fault |
| restart | output | 1 | Instruction must be reissued |
| cnt_out | output | REG_W | Count register |
| src_out | output | REG_W | Source pointer |
| dst_out | output | REG_W | Destination pointer |
| zf_out | output | 1 | Zero flag |

## Verification
Random operations mix all three repeat kinds and all address widths with short counts. Their upper count bits are filled with noise, so any write or test of bits outside the active width shows up. Random zero-flag streams, interrupt points and fault points tell apart the four ways the loop can end, including the case where the count reaches zero on the same element that would also meet the flag condition. Directed cases cover a zero start with noise in the high bits, a 64-bit count ended only by an interrupt, a plain repeat fed alternating flags, port elements under the wide flag, and a compare fault after several elements have changed the flag.

// File: rtl/rep_seq_pkg.sv
package rep_seq_pkg;
  localparam int W16 = 16;
  localparam int W32 = 32;

  typedef enum logic [1:0] {RK_PLAIN = 2'd0, RK_WHILE_EQ = 2'd1, RK_WHILE_NE = 2'd2} rep_kind_e;
  typedef enum logic [1:0] {AW_16 = 2'd0, AW_32 = 2'd1, AW_64 = 2'd2} addr_w_e;
  typedef enum logic [1:0] {END_COUNT = 2'd0, END_FLAG = 2'd1, END_IRQ = 2'd2, END_FAULT = 2'd3} end_cause_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_CHECK = 2'd1, ST_ISSUE = 2'd2} seq_state_e;
endpackage

// File: rtl/rep_count_unit.sv
module rep_count_unit
  import rep_seq_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic [REG_W-1:0] cur,
  input  logic [1:0]       aw,
  input  logic             wide,
  output logic             sel_zero,
  output logic             dec_zero,
  output logic [REG_W-1:0] dec_val
);
  localparam logic [REG_W-1:0] MASK16 = {{(REG_W-W16){1'b0}}, {W16{1'b1}}};
  localparam logic [REG_W-1:0] MASK32 = {{(REG_W-W32){1'b0}}, {W32{1'b1}}};

  logic [REG_W-1:0] mask;
  logic [REG_W-1:0] dec_full;

  always_comb begin
    if (aw == AW_16)                mask = MASK16;
    else if (aw == AW_64 && wide)   mask = '1;
    else                            mask = MASK32;
    dec_full = (cur & mask) - {{(REG_W-1){1'b0}}, 1'b1};
    sel_zero = ((cur & mask) == '0);
    dec_zero = ((dec_full & mask) == '0);
    dec_val  = (cur & ~mask) | (dec_full & mask);
  end
endmodule

// File: rtl/rep_ptr_step.sv
module rep_ptr_step #(
  parameter int REG_W = 64
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic [1:0]       size_code,
  input  logic             wide,
  input  logic             port_op,
  input  logic             down,
  output logic [REG_W-1:0] src_nx,
  output logic [REG_W-1:0] dst_nx
);
  logic [3:0]       nbytes;
  logic [REG_W-1:0] step;

  always_comb begin
    case (size_code)
      2'd0:    nbytes = 4'd1;
      2'd1:    nbytes = 4'd2;
      default: nbytes = (wide && !port_op) ? 4'd8 : 4'd4;
    endcase
    step   = {{(REG_W-4){1'b0}}, nbytes};
    src_nx = down ? src - step : src + step;
    dst_nx = down ? dst - step : dst + step;
  end
endmodule

// File: rtl/rep_ctrl.sv
module rep_ctrl
  import rep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] kind,
  input  logic       sel_zero,
  input  logic       dec_zero,
  input  logic       irq,
  input  logic       el_ack,
  input  logic       el_fault,
  input  logic       el_zf,
  output logic       el_req,
  output logic       busy,
  output logic       load_en,
  output logic       step_en,
  output logic       fin_en,
  output logic [1:0] fin_cause
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    el_req    = 1'b0;
    load_en   = 1'b0;
    step_en   = 1'b0;
    fin_en    = 1'b0;
    fin_cause = END_COUNT;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (sel_zero) begin
          fin_en  = 1'b1;
          state_d = ST_IDLE;
        end else if (irq) begin
          fin_en    = 1'b1;
          fin_cause = END_IRQ;
          state_d   = ST_IDLE;
        end else begin
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        el_req = 1'b1;
        if (el_ack) begin
          if (el_fault) begin
            fin_en    = 1'b1;
            fin_cause = END_FAULT;
            state_d   = ST_IDLE;
          end else begin
            step_en = 1'b1;
            if (dec_zero) begin
              fin_en  = 1'b1;
              state_d = ST_IDLE;
            end else if ((kind == RK_WHILE_EQ && !el_zf) || (kind == RK_WHILE_NE && el_zf)) begin
              fin_en    = 1'b1;
              fin_cause = END_FLAG;
              state_d   = ST_IDLE;
            end else begin
              state_d = ST_CHECK;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/rep_seq.sv
module rep_seq
  import rep_seq_pkg::*;
#(
  parameter int REG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       rep_kind,
  input  logic [1:0]       addr_w,
  input  logic             wide,
  input  logic             port_op,
  input  logic             cmp_op,
  input  logic [1:0]       size_code,
  input  logic             dir_down,
  input  logic [REG_W-1:0] cnt_in,
  input  logic [REG_W-1:0] src_in,
  input  logic [REG_W-1:0] dst_in,
  input  logic             flag_zf_in,
  input  logic             irq_pending,
  output logic             el_req,
  input  logic             el_ack,
  input  logic             el_zf,
  input  logic             el_fault,
  output logic             busy,
  output logic             done,
  output logic [1:0]       cause,
  output logic             restart,
  output logic [REG_W-1:0] cnt_out,
  output logic [REG_W-1:0] src_out,
  output logic [REG_W-1:0] dst_out,
  output logic             zf_out
);
  logic [REG_W-1:0] cnt_q, src_q, dst_q;
  logic [REG_W-1:0] cnt_dec, src_nx, dst_nx;
  logic [1:0]       kind_q, aw_q, size_q, cause_q;
  logic             wide_q, port_q, cmp_q, down_q;
  logic             zf_q, zf_saved_q, done_q;
  logic             sel_zero, dec_zero;
  logic             load_en, step_en, fin_en;
  logic [1:0]       fin_cause;

  rep_count_unit #(.REG_W(REG_W)) u_cnt (
    .cur(cnt_q), .aw(aw_q), .wide(wide_q),
    .sel_zero(sel_zero), .dec_zero(dec_zero), .dec_val(cnt_dec)
  );

  rep_ptr_step #(.REG_W(REG_W)) u_ptr (
    .src(src_q), .dst(dst_q), .size_code(size_q), .wide(wide_q),
    .port_op(port_q), .down(down_q), .src_nx(src_nx), .dst_nx(dst_nx)
  );

  rep_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .kind(kind_q),
    .sel_zero(sel_zero), .dec_zero(dec_zero), .irq(irq_pending),
    .el_ack(el_ack), .el_fault(el_fault), .el_zf(el_zf),
    .el_req(el_req), .busy(busy), .load_en(load_en), .step_en(step_en),
    .fin_en(fin_en), .fin_cause(fin_cause)
  );

  // Next-state values for the working registers
  logic [REG_W-1:0] cnt_d, src_d, dst_d;
  logic             zf_d, regs_en, zf_en;

  always_comb begin
    regs_en = load_en | step_en;
    cnt_d   = load_en ? cnt_in : cnt_dec;
    src_d   = load_en ? src_in : src_nx;
    dst_d   = load_en ? dst_in : dst_nx;
    zf_en   = 1'b0;
    zf_d    = zf_q;
    if (load_en) begin
      zf_en = 1'b1;
      zf_d  = flag_zf_in;
    end else if (step_en && cmp_q) begin
      zf_en = 1'b1;
      zf_d  = el_zf;
    end else if (fin_en && fin_cause == END_FAULT && cmp_q) begin
      zf_en = 1'b1;
      zf_d  = zf_saved_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      src_q      <= '0;
      dst_q      <= '0;
      zf_q       <= 1'b0;
      zf_saved_q <= 1'b0;
      kind_q     <= RK_PLAIN;
      aw_q       <= AW_16;
      size_q     <= 2'd0;
      wide_q     <= 1'b0;
      port_q     <= 1'b0;
      cmp_q      <= 1'b0;
      down_q     <= 1'b0;
      done_q     <= 1'b0;
      cause_q    <= END_COUNT;
    end else begin
      if (regs_en) begin
        cnt_q <= cnt_d;
        src_q <= src_d;
        dst_q <= dst_d;
      end
      if (zf_en) zf_q <= zf_d;
      if (load_en) begin
        zf_saved_q <= flag_zf_in;
        kind_q     <= rep_kind;
        aw_q       <= addr_w;
        size_q     <= size_code;
        wide_q     <= wide;
        port_q     <= port_op;
        cmp_q      <= cmp_op;
        down_q     <= dir_down;
      end
      done_q <= fin_en;
      if (fin_en) cause_q <= fin_cause;
    end
  end

  assign done    = done_q;
  assign cause   = cause_q;
  assign restart = done_q && (cause_q == END_IRQ || cause_q == END_FAULT);
  assign cnt_out = cnt_q;
  assign src_out = src_q;
  assign dst_out = dst_q;
  assign zf_out  = zf_q;
endmodule

// File: rtl/rep_seq_chk.sv
module rep_seq_chk
  import rep_seq_pkg::*;
#(
  parameter int REG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             el_req,
  input logic             el_ack,
  input logic             el_fault,
  input logic             irq_pending,
  input logic             busy,
  input logic [1:0]       aw_q,
  input logic [REG_W-1:0] cnt_out,
  input logic [REG_W-1:0] src_out,
  input logic [REG_W-1:0] dst_out
);
  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(el_req) |-> !$past(irq_pending));

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (el_req && !el_ack) |=> el_req);

  p_dec_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (el_req && el_ack && !el_fault) |=> (cnt_out[15:0] == $past(cnt_out[15:0]) - 16'd1));

  p_fault_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (el_req && el_ack && el_fault) |=> ($stable(cnt_out) && $stable(src_out) && $stable(dst_out)));

  p_upper_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && aw_q == AW_16) |=> (cnt_out[REG_W-1:16] == $past(cnt_out[REG_W-1:16])));
endmodule

bind rep_seq rep_seq_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .el_req(el_req), .el_ack(el_ack),
  .el_fault(el_fault), .irq_pending(irq_pending), .busy(busy),
  .aw_q(aw_q), .cnt_out(cnt_out), .src_out(src_out), .dst_out(dst_out)
);

// File: tb/rep_seq_test.sv
module rep_seq_test;
  localparam int PERIOD = 10;
  localparam int NONE = 999;

  logic clk, rst_n, start;
  logic [1:0] rep_kind, addr_w, size_code;
  logic wide, port_op, cmp_op, dir_down, flag_zf_in, irq_pending;
  logic [63:0] cnt_in, src_in, dst_in;
  logic el_req, el_ack, el_zf, el_fault, busy, done, restart, zf_out;
  logic [1:0] cause;
  logic [63:0] cnt_out, src_out, dst_out;

  int checks = 0;
  int errors = 0;
  bit zf_seq [64];
  int fault_idx, irq_idx;

  rep_seq uut (.*);

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mask_of(input logic [1:0] aw, input logic w);
    if (aw == 2'd0) return 64'hFFFF;
    if (aw == 2'd2 && w) return '1;
    return 64'hFFFF_FFFF;
  endfunction

  function automatic logic [63:0] bytes_of(input logic [1:0] sc, input logic w, input logic prt);
    if (sc == 2'd0) return 64'd1;
    if (sc == 2'd1) return 64'd2;
    return (w && !prt) ? 64'd8 : 64'd4;
  endfunction

  task automatic run_case(input string name);
    logic [63:0] m, c, bsz, e_src, e_dst;
    int n, e_cause, e_reqs, n_ok, reqs, guard;
    logic e_zf, zfe;
    // expected outcome
    m = mask_of(addr_w, wide);
    c = cnt_in & m;
    n = 0;
    e_zf = flag_zf_in;
    e_cause = 0;
    if (c != 0) begin
      forever begin
        if (n == irq_idx) begin e_cause = 2; break; end
        if (n == fault_idx) begin e_cause = 3; break; end
        zfe = zf_seq[n];
        if (cmp_op) e_zf = zfe;
        c = c - 64'd1;
        n++;
        if ((c & m) == 0) begin e_cause = 0; break; end
        if (rep_kind == 2'd1 && !zfe) begin e_cause = 1; break; end
        if (rep_kind == 2'd2 && zfe) begin e_cause = 1; break; end
      end
    end
    if (e_cause == 3 && cmp_op) e_zf = flag_zf_in;
    e_reqs = n + ((e_cause == 3) ? 1 : 0);
    bsz = bytes_of(size_code, wide, port_op);
    e_src = dir_down ? src_in - bsz * 64'(n) : src_in + bsz * 64'(n);
    e_dst = dir_down ? dst_in - bsz * 64'(n) : dst_in + bsz * 64'(n);

    // drive
    n_ok = 0;
    reqs = 0;
    guard = 0;
    irq_pending = (n_ok == irq_idx);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (el_req && ($urandom % 2 == 0)) begin
        el_ack = 1'b1;
        el_zf = zf_seq[n_ok];
        el_fault = (n_ok == fault_idx);
        reqs++;
        if (n_ok != fault_idx) n_ok++;
      end else begin
        el_ack = 1'b0;
        el_zf = $urandom % 2;
        el_fault = $urandom % 2;
      end
      irq_pending = (n_ok == irq_idx);
      @(negedge clk);
      guard++;
      if (guard > 5000) begin
        checks++; errors++;
        $display("FAIL R12 %s hung actual=busy expected=done", name);
        break;
      end
    end
    el_ack = 1'b0;
    el_fault = 1'b0;
    chk({"R6 cause ", name}, 64'(cause), 64'(e_cause));
    chk({"R1 count ", name}, cnt_out, (cnt_in & ~m) | (c & m));
    chk({"R9 src ", name}, src_out, e_src);
    chk({"R9 dst ", name}, dst_out, e_dst);
    chk({"R11 zf ", name}, 64'(zf_out), 64'(e_zf));
    chk({"R7 restart ", name}, 64'(restart), 64'(e_cause >= 2));
    chk({"R12 attempts ", name}, 64'(reqs), 64'(e_reqs));
    irq_pending = 1'b0;
    @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] k, input logic [1:0] aw, input logic w,
                       input logic prt, input logic cmp, input logic [1:0] sc, input logic dn);
    rep_kind = k; addr_w = aw; wide = w; port_op = prt; cmp_op = cmp;
    size_code = sc; dir_down = dn;
    src_in = {$urandom, $urandom};
    dst_in = {$urandom, $urandom};
    flag_zf_in = $urandom % 2;
    fault_idx = NONE;
    irq_idx = NONE;
    foreach (zf_seq[i]) zf_seq[i] = $urandom % 2;
  endtask

  initial begin
    #(PERIOD * 150000);
    checks++; errors++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; el_ack = 1'b0; el_zf = 1'b0; el_fault = 1'b0;
    irq_pending = 1'b0; cnt_in = '0; src_in = '0; dst_in = '0;
    rep_kind = 2'd0; addr_w = 2'd0; wide = 1'b0; port_op = 1'b0; cmp_op = 1'b0;
    size_code = 2'd0; dir_down = 1'b0; flag_zf_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset el_req", 64'(el_req), 64'd0);
    chk("R2 reset done", 64'(done), 64'd0);
    chk("R4 reset busy", 64'(busy), 64'd0);

    // R2: zero active count with noise above the 16-bit field
    setup(2'd1, 2'd0, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0);
    cnt_in = 64'hDEAD_BEEF_1234_0000;
    run_case("R2 zero16");
    // R2: zero 32-bit count with upper half set
    setup(2'd0, 2'd2, 1'b0, 1'b0, 1'b0, 2'd2, 1'b0);
    cnt_in = 64'h0000_0100_0000_0000;
    run_case("R2 zero32");
    // R1: 64-bit count reached only through high bits, ended by interrupt (R3)
    setup(2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0);
    cnt_in = 64'h0000_0100_0000_0000;
    irq_idx = 3;
    run_case("R1 wide64 R3");
    // R3: interrupt before first element
    setup(2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1);
    cnt_in = 64'd9;
    irq_idx = 0;
    run_case("R3 irq0");
    // R5: plain repeat with alternating flags
    setup(2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0);
    foreach (zf_seq[i]) zf_seq[i] = i[0];
    cnt_in = 64'd12;
    run_case("R5 plain");
    // R10: port element under wide flag stays 4 bytes
    setup(2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0);
    cnt_in = 64'd5;
    run_case("R10 port");
    // R10: non-port element promoted to 8 bytes, going down
    setup(2'd0, 2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1);
    cnt_in = 64'd4;
    run_case("R10 wide8");
    // R8: compare fault after flags changed
    setup(2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0);
    foreach (zf_seq[i]) zf_seq[i] = 1'b1;
    flag_zf_in = 1'b0;
    cnt_in = 64'd10;
    fault_idx = 4;
    run_case("R8 fault");
    // R4: count ends on the same element that meets the flag condition
    setup(2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0);
    foreach (zf_seq[i]) zf_seq[i] = 1'b1;
    zf_seq[2] = 1'b0;
    cnt_in = 64'hFFFF_FFFF_FFFF_0003;
    run_case("R4 tie");
    // R6: repeat-while-not-equal stops on flag set
    setup(2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0);
    foreach (zf_seq[i]) zf_seq[i] = 1'b0;
    zf_seq[5] = 1'b1;
    cnt_in = 64'd20;
    run_case("R6 ne");

    // random mix
    for (int t = 0; t < 300; t++) begin
      logic [63:0] m, r;
      setup(2'($urandom % 3), 2'($urandom % 3), 1'($urandom % 2), 1'($urandom % 2),
            1'($urandom % 2), 2'($urandom % 3), 1'($urandom % 2));
      foreach (zf_seq[i]) zf_seq[i] = ($urandom % 5) != 0;
      if ($urandom % 2) foreach (zf_seq[i]) zf_seq[i] = !zf_seq[i];
      m = mask_of(addr_w, wide);
      r = {$urandom, $urandom};
      cnt_in = (r & ~m) | 64'($urandom % 21);
      if ($urandom % 4 == 0) irq_idx = $urandom % 12;
      if ($urandom % 5 == 0) fault_idx = $urandom % 12;
      run_case($sformatf("rand%0d", t));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule